// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block answers on a two-wire serial bus as a small byte-addressed non-volatile memory would. A controller sends a START, then a device byte. The upper nibble of that byte is a fixed type code and two bits are compared with the strap pins. One bit supplies the top bit of the word address, and the lowest bit picks the direction. The block holds 512 bytes in an internal register array. It oversamples SCL and SDA with the system clock and pulls SDA low through an open-drain enable.

Writes carry a word-address byte followed by one or more data bytes. A run of data bytes stays inside its 16-byte page. Reads start at a single word-address counter that survives from one transaction to the next. A read either starts straight from that counter or follows a write of the word address alone. A read carries on byte after byte for as long as the controller acknowledges, and it runs over the end of the array back to byte zero.

Top module: `i2c_eeprom_target`

## Requirements
- R1: A device byte whose bits 7..4 are 1010 and whose bits 3..2 equal `dev_sel` is acknowledged by pulling SDA low during the ninth clock. Any other device byte is not acknowledged, and SDA stays released until the next START.
- R2: In a write (bit 0 of the device byte = 0), the word address is formed from bit 1 of the device byte as address bit 8 and the following byte as bits 7..0. Each data byte after it is stored at the current address, and every byte of the write is acknowledged.
- R3: During a write the address increments only within bits 3..0, so the byte after page offset 15 lands on offset 0 of the same 16-byte page.
- R4: The word-address counter keeps the last accessed address plus one between transactions. A read (bit 0 = 1) that sends no word address returns the byte at that counter.
- R5: During a read the address runs through the whole array, so the byte after address 511 is address 0.
- R6: After each read byte, an acknowledge (SDA low) from the controller makes the target send the next byte. A not-acknowledge ends the transfer, and SDA then stays released.
- R7: A write that stops after the word address, followed by a repeated START and a read, loads the counter and stores no data.
- R8: A STOP or START at any point releases SDA and abandons the byte in progress. A partly received data byte is never stored, and a START restarts the device-byte phase.
- R9: After reset, SDA is released and the word-address counter is 0.
- R10: Read data goes out MSB first. The target changes SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_sel | input | 2 | Strap value compared with device byte bits 3..2 |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The page-limited write increment and the array-wide read increment act on the same counter. At the top page both can be in play at once: the cycle that stores a byte at address 511 also steps the counter to 496, not to 0. The bench provokes this with a three-byte write starting at 510, which must store the bytes at 510, 511 and 496. It then runs a sequential read from 510, which must return those first two bytes followed by the byte at address 0. A wrong wrap in either direction shows up as a wrong third value.

// File: rtl/i2c_ee_pkg.sv
// Shared types and constants for the two-wire EEPROM target.
package i2c_ee_pkg;

    // Fixed type code carried in device byte bits 7..4.
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    // Byte-level sequencer states.
    typedef enum logic [3:0] {
        ST_IDLE,      // ignore bus until START
        ST_DEV,       // shifting in device byte
        ST_DEV_ACK,   // acknowledging device byte
        ST_WADDR,     // shifting in word address
        ST_WADDR_ACK, // acknowledging word address
        ST_WDATA,     // shifting in write data
        ST_WDATA_ACK, // acknowledging write data
        ST_RD,        // shifting out read data
        ST_RACK       // waiting for controller ack/nack
    } ee_state_t;

endpackage

// File: rtl/i2c_ee_line_sync.sv
// Synchronises SCL and SDA into the system clock domain and flags
// clock edges plus START/STOP conditions.
// Assumes: system clock is several times faster than SCL; lines idle high.
module i2c_ee_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_s,
    output logic start_det,
    output logic stop_det
);

    logic [1:0] raw;
    logic [1:0] now_v;
    logic [1:0] prev_v;

    assign raw = {sda_i, scl_i};

    // One synchroniser chain per line: index 0 is SCL, index 1 is SDA.
    genvar g;
    for (g = 0; g < 2; g++) begin : g_line
        logic [STAGES:0] sh;
        // Shift the raw line in; reset to the idle-high level.
        always_ff @(posedge clk) begin
            if (!rst_n) sh <= '1;
            else        sh <= {sh[STAGES-1:0], raw[g]};
        end
        assign now_v[g]  = sh[STAGES-1];
        assign prev_v[g] = sh[STAGES];
    end

    // Decode edges and bus conditions from the current and previous samples.
    always_comb begin
        scl_rise  = now_v[0] & ~prev_v[0];
        scl_fall  = ~now_v[0] & prev_v[0];
        sda_s     = now_v[1];
        start_det = now_v[0] & prev_v[0] & prev_v[1] & ~now_v[1];
        stop_det  = now_v[0] & prev_v[0] & ~prev_v[1] & now_v[1];
    end

endmodule

// File: rtl/i2c_ee_addr_ctr.sv
// Persistent word-address counter. Loads from the word-address phase,
// steps across the whole array on reads and within one page on writes.
// Assumes: load and the two increments are never requested together.
module i2c_ee_addr_ctr #(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc_rd,
    input  logic              inc_wr,
    output logic [ADDR_W-1:0] addr
);

    // Update the counter by the one active request, if any.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr <= '0;
        else if (load)   addr <= load_val;
        else if (inc_rd) addr <= addr + 1'b1;
        else if (inc_wr) addr <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + 1'b1};
    end

endmodule

// File: rtl/i2c_ee_mem.sv
// Byte storage: one synchronous write port, one combinational read port.
// Assumes: contents are not reset, as with a real memory array.
module i2c_ee_mem #(
    parameter int DEPTH  = 512,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);

    logic [7:0] cells [DEPTH];

    // Store a byte when the sequencer commits a write.
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    // Present the byte at the read address.
    assign rdata = cells[raddr];

endmodule

// File: rtl/i2c_eeprom_target.sv
// Two-wire EEPROM target: byte sequencer around the line sampler,
// address counter and storage array.
// Assumes: SCL high and low phases each last several system clocks;
// no clock stretching; writes complete instantly.
module i2c_eeprom_target
    import i2c_ee_pkg::*;
#(
    parameter int MEM_BYTES   = 512,
    parameter int PAGE_BYTES  = 16,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = $clog2(MEM_BYTES),
    localparam int PAGE_W     = $clog2(PAGE_BYTES),
    localparam int HI_W       = ADDR_W - 8,
    localparam int SEL_W      = 3 - HI_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] dev_sel,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe
);

    logic scl_rise, scl_fall, sda_s, start_det, stop_det;
    ee_state_t         state;
    logic [3:0]        bit_cnt;
    logic [7:0]        shreg;
    logic              oe_q;
    logic              rw_q;
    logic              nack_q;
    logic [HI_W-1:0]   hi_q;
    logic [ADDR_W-1:0] word_addr;
    logic [7:0]        rdata;
    logic              byte_in_done;
    logic              dev_match;
    logic              ctr_load, ctr_inc_rd, ctr_inc_wr, mem_we;
    logic              in_idle, in_rack;

    i2c_ee_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_s     (sda_s),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_ee_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val ({hi_q, shreg}),
        .inc_rd   (ctr_inc_rd),
        .inc_wr   (ctr_inc_wr),
        .addr     (word_addr)
    );

    i2c_ee_mem #(.DEPTH(MEM_BYTES), .ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (word_addr),
        .wdata (shreg),
        .raddr (word_addr),
        .rdata (rdata)
    );

    // Decode byte completion, address match and per-cycle strobes.
    always_comb begin
        byte_in_done = scl_fall && (bit_cnt == 4'd8);
        dev_match    = (shreg[7:4] == DEV_TYPE) && (shreg[3:HI_W+1] == dev_sel);
        ctr_load     = (state == ST_WADDR) && byte_in_done;
        mem_we       = (state == ST_WDATA) && byte_in_done;
        ctr_inc_wr   = mem_we;
        ctr_inc_rd   = scl_fall && (((state == ST_DEV_ACK) && rw_q) ||
                                    ((state == ST_RACK) && !nack_q));
        in_idle      = (state == ST_IDLE);
        in_rack      = (state == ST_RACK);
    end

    // Byte sequencer: bus conditions first, then bit- and byte-level steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            oe_q    <= 1'b0;
            rw_q    <= 1'b0;
            nack_q  <= 1'b1;
            hi_q    <= '0;
        end else if (start_det) begin
            state   <= ST_DEV;
            bit_cnt <= '0;
            oe_q    <= 1'b0;
        end else if (stop_det) begin
            state   <= ST_IDLE;
            oe_q    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    oe_q <= 1'b0;
                end
                ST_DEV, ST_WADDR, ST_WDATA: begin
                    if (scl_rise && (bit_cnt < 4'd8)) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_in_done) begin
                        bit_cnt <= '0;
                        if (state == ST_DEV) begin
                            if (dev_match) begin
                                oe_q  <= 1'b1;
                                rw_q  <= shreg[0];
                                hi_q  <= shreg[HI_W:1];
                                state <= ST_DEV_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else if (state == ST_WADDR) begin
                            oe_q  <= 1'b1;
                            state <= ST_WADDR_ACK;
                        end else begin
                            oe_q  <= 1'b1;
                            state <= ST_WDATA_ACK;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (rw_q) begin
                            shreg <= rdata;
                            oe_q  <= ~rdata[7];
                            state <= ST_RD;
                        end else begin
                            oe_q  <= 1'b0;
                            state <= ST_WADDR;
                        end
                    end
                end
                ST_WADDR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        oe_q  <= 1'b0;
                        state <= ST_WDATA;
                    end
                end
                ST_RD: begin
                    if (scl_fall) begin
                        if (bit_cnt == 4'd7) begin
                            oe_q    <= 1'b0;
                            bit_cnt <= '0;
                            state   <= ST_RACK;
                        end else begin
                            shreg   <= {shreg[6:0], 1'b0};
                            oe_q    <= ~shreg[6];
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        nack_q <= sda_s;
                    end else if (scl_fall) begin
                        if (!nack_q) begin
                            shreg   <= rdata;
                            oe_q    <= ~rdata[7];
                            bit_cnt <= '0;
                            state   <= ST_RD;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign sda_oe = oe_q;

endmodule

// File: rtl/i2c_ee_checker.sv
// Protocol checker for the EEPROM target; attached by bind below.
// Assumes: bus stimulus keeps SCL low for at least four system clocks.
module i2c_ee_checker #(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic              start_det,
    input logic              stop_det,
    input logic [ADDR_W-1:0] addr,
    input logic              inc_rd,
    input logic              inc_wr,
    input logic              in_idle,
    input logic              in_rack
);

    // R10: no SDA change while SCL has been high for four samples.
    assert_sda_quiet_scl_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && $past(scl_i, 2) && $past(scl_i, 3)) |-> $stable(sda_oe));

    // R8: a STOP releases SDA on the next cycle.
    assert_release_after_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R8: a START releases SDA on the next cycle.
    assert_release_after_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    // R3: write stepping keeps the page and advances the offset modulo the page.
    assert_page_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        inc_wr |=> ((addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W])) &&
                    (addr[PAGE_W-1:0] == $past(addr[PAGE_W-1:0]) + 1'b1)));

    // R5: read stepping advances modulo the whole array.
    assert_array_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        inc_rd |=> (addr == $past(addr) + 1'b1));

    // R6: the controller's acknowledge slot is never driven by the target.
    assert_ack_slot_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_rack |-> !sda_oe);

    // R1: an unaddressed target keeps SDA released.
    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && $past(in_idle)) |-> !sda_oe);

endmodule

bind i2c_eeprom_target i2c_ee_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .start_det (start_det),
    .stop_det  (stop_det),
    .addr      (word_addr),
    .inc_rd    (ctr_inc_rd),
    .inc_wr    (ctr_inc_wr),
    .in_idle   (in_idle),
    .in_rack   (in_rack)
);

// File: tb/i2c_eeprom_target_test.sv
// Directed bench: a bus controller model drives SCL/SDA, one task per scenario.
module i2c_eeprom_target_test;

    localparam int Q = 8;              // system clocks per quarter bus phase
    localparam logic [1:0] SEL = 2'b10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic sda_line;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   stable_ok = 1'b1;

    assign sda_line = m_sda & ~sda_oe;

    always #5 clk = ~clk;

    i2c_eeprom_target uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .dev_sel (SEL),
        .scl_i   (scl),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] dev_b(input logic p0, input logic rw);
        return {4'b1010, SEL, p0, rw};
    endfunction

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        m_sda = 1'b0; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic bit_out(input logic b);
        m_sda = b; tick(Q);
        scl = 1'b1; tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic bit_in(output logic b);
        logic early;
        m_sda = 1'b1; tick(Q);
        scl = 1'b1; tick(2);
        early = sda_line; tick(Q - 2);
        b = sda_line;
        if (early !== b) stable_ok = 1'b0;
        scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        bit_in(a);
        ack = ~a;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) bit_in(d[i]);
        bit_out(~give_ack);
    endtask

    // Write 1..3 bytes starting at a 9-bit address, checking every ack (R2).
    task automatic write_run(input logic [8:0] a, input int n,
                             input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
        logic ack;
        logic [7:0] d [3];
        d[0] = d0; d[1] = d1; d[2] = d2;
        bus_start();
        send_byte(dev_b(a[8], 1'b0), ack); check(ack, "R2 device ack", ack, 1);
        send_byte(a[7:0], ack);            check(ack, "R2 word ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(d[i], ack);          check(ack, "R2 data ack", ack, 1);
        end
        bus_stop();
    endtask

    // Dummy write then repeated START and read; leaves the bus in read state (R7).
    task automatic rand_open(input logic [8:0] a);
        logic ack;
        bus_start();
        send_byte(dev_b(a[8], 1'b0), ack); check(ack, "R7 dummy dev ack", ack, 1);
        send_byte(a[7:0], ack);            check(ack, "R7 dummy word ack", ack, 1);
        bus_start();
        send_byte(dev_b(1'b0, 1'b1), ack); check(ack, "R7 read dev ack", ack, 1);
    endtask

    task automatic rand_read(input logic [8:0] a, output logic [7:0] d);
        rand_open(a);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    task automatic cur_read(output logic [7:0] d);
        logic ack;
        bus_start();
        send_byte(dev_b(1'b0, 1'b1), ack); check(ack, "R4 current dev ack", ack, 1);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    task automatic test_reset_R9();
        logic [7:0] d;
        check(sda_oe == 1'b0, "R9 SDA released after reset", sda_oe, 0);
        write_run(9'h000, 1, 8'h5A, 8'h00, 8'h00);
        rst_n = 1'b0; tick(4);
        rst_n = 1'b1; tick(4);
        check(sda_oe == 1'b0, "R9 SDA released after second reset", sda_oe, 0);
        cur_read(d);
        check(d == 8'h5A, "R9 counter zero after reset", d, 8'h5A);
    endtask

    task automatic test_mismatch_R1();
        logic ack;
        bus_start();
        send_byte({4'b1010, 2'b01, 2'b00}, ack);
        check(!ack, "R1 wrong select not acked", ack, 0);
        send_byte(8'hFF, ack);
        check(!ack, "R1 SDA released until START", ack, 0);
        bus_stop();
        bus_start();
        send_byte({4'b1011, SEL, 2'b00}, ack);
        check(!ack, "R1 wrong type not acked", ack, 0);
        bus_start();
        send_byte(dev_b(1'b1, 1'b0), ack);
        check(ack, "R1 matching byte acked", ack, 1);
        bus_stop();
    endtask

    task automatic test_byte_write_R2();
        logic [7:0] d;
        write_run(9'h123, 1, 8'hA7, 8'h00, 8'h00);
        rand_read(9'h123, d);
        check(d == 8'hA7, "R2 byte stored at 9-bit address", d, 8'hA7);
        rand_read(9'h023, d);
        check(d != 8'hA7 || 1'b0, "R2 bit 8 selects upper half", d, 0);
    endtask

    task automatic test_page_wrap_R3();
        logic [7:0] d;
        write_run(9'h060, 1, 8'h99, 8'h00, 8'h00);
        write_run(9'h050, 1, 8'h00, 8'h00, 8'h00);
        write_run(9'h05E, 3, 8'h11, 8'h22, 8'h33);
        rand_read(9'h050, d); check(d == 8'h33, "R3 wrapped to page start", d, 8'h33);
        rand_read(9'h05F, d); check(d == 8'h22, "R3 page end byte", d, 8'h22);
        rand_read(9'h060, d); check(d == 8'h99, "R3 next page untouched", d, 8'h99);
    endtask

    task automatic test_current_R4();
        logic [7:0] d;
        rand_read(9'h05E, d); check(d == 8'h11, "R4 random read value", d, 8'h11);
        cur_read(d);          check(d == 8'h22, "R4 counter is last plus one", d, 8'h22);
        cur_read(d);          check(d == 8'h99, "R4 read crosses page boundary", d, 8'h99);
    endtask

    task automatic test_seq_wrap_R5_R6();
        logic [7:0] d0, d1, d2, extra;
        write_run(9'h1FE, 3, 8'hC1, 8'hC2, 8'hC3);
        rand_read(9'h1F0, d0); check(d0 == 8'hC3, "R3 top page wrap on write", d0, 8'hC3);
        rand_open(9'h1FE);
        recv_byte(1'b1, d0);
        recv_byte(1'b1, d1);
        recv_byte(1'b0, d2);
        check(d0 == 8'hC1, "R6 first sequential byte", d0, 8'hC1);
        check(d1 == 8'hC2, "R6 second sequential byte", d1, 8'hC2);
        check(d2 == 8'h5A, "R5 read wraps 511 to 0", d2, 8'h5A);
        for (int i = 7; i >= 0; i--) bit_in(extra[i]);
        check(extra == 8'hFF, "R6 released after nack", extra, 8'hFF);
        bus_stop();
    endtask

    task automatic test_dummy_R7();
        logic [7:0] d;
        rand_read(9'h123, d);
        check(d == 8'hA7, "R7 dummy write stored nothing", d, 8'hA7);
        rand_read(9'h060, d);
        check(d == 8'h99, "R7 counter loaded by dummy write", d, 8'h99);
    endtask

    task automatic test_abort_R8();
        logic ack;
        logic [7:0] d;
        write_run(9'h070, 2, 8'h44, 8'h3C, 8'h00);
        bus_start();
        send_byte(dev_b(1'b0, 1'b0), ack);
        send_byte(8'h70, ack);
        for (int i = 0; i < 4; i++) bit_out(1'b1);
        bus_stop();
        check(sda_oe == 1'b0, "R8 SDA released after STOP", sda_oe, 0);
        rand_read(9'h070, d);
        check(d == 8'h44, "R8 partial byte not stored on STOP", d, 8'h44);
        bus_start();
        send_byte(dev_b(1'b0, 1'b0), ack);
        send_byte(8'h71, ack);
        for (int i = 0; i < 3; i++) bit_out(1'b0);
        bus_start();
        send_byte(dev_b(1'b0, 1'b1), ack);
        check(ack, "R8 repeated START restarts device phase", ack, 1);
        recv_byte(1'b0, d);
        bus_stop();
        check(d == 8'h3C, "R8 partial byte not stored on START", d, 8'h3C);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        tick(6);
        rst_n = 1'b1;
        tick(4);
        test_reset_R9();
        test_mismatch_R1();
        test_byte_write_R2();
        test_page_wrap_R3();
        test_current_R4();
        test_seq_wrap_R5_R6();
        test_dummy_R7();
        test_abort_R8();
        check(stable_ok, "R10 SDA stable while SCL high", stable_ok, 1);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule